// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block gathers the interrupt sources of a serial peripheral controller into one status word and one interrupt line. Two of the sources follow FIFO occupancy directly: a transmit-side "running low" condition and a receive-side "filling up" condition. Each is found by comparing a FIFO level with a programmable threshold. The other four sources are sticky: transmit overflow, receive underflow, receive overflow and multi-master contention. Each of these is latched from a single-cycle event pulse and held until software clears it.

Software sees two views of the sources. The first is the raw status, which shows every source whatever its enable. The second is the masked status, which is the raw status filtered by a five-bit enable register. Each sticky source has its own clear strobe, raised by the bus decoder when the matching clear location is read. One more strobe clears all four sticky sources at once. The interrupt line is the registered OR of the masked status. The FIFOs and the bus decoding sit outside this block.

Top module: `spi_irq_unit`

## Requirements
- R1: Both status words use the same bit order. Bit 0 is transmit low-water, bit 1 is transmit overflow, bit 2 is receive underflow, bit 3 is receive overflow, bit 4 is receive high-water and bit 5 is contention. After reset, both status words and `irq` read 0.
- R2: Raw bit 0 is 1 exactly when `tx_level <= tx_thresh` held at the previous clock edge. No clear strobe changes it.
- R3: Raw bit 4 is 1 exactly when `rx_level > rx_thresh` held at the previous clock edge. No clear strobe changes it.
- R4: A pulse on `ev_tx_ovf`, `ev_rx_unf`, `ev_rx_ovf` or `ev_contend` sets raw bit 1, 2, 3 or 5 at the next edge. The bit then holds until a clear strobe removes it.
- R5: `clr_tx_ovf`, `clr_rx_unf`, `clr_rx_ovf` and `clr_contend` each clear only raw bit 1, 2, 3 or 5 at the next edge.
- R6: `clr_all` clears raw bits 1, 2, 3 and 5 together at the next edge. It leaves bits 0 and 4 alone.
- R7: If an event pulse and a clear of the same bit arrive in the same cycle, the bit is 1 after the edge.
- R8: When `mask_we` is high, the enable register loads `mask_wdata` at the next edge. Its reset value is 0. `masked_stat[i]` equals `raw_stat[i]` AND enable bit i for bits 0 to 4. Bit 5 has no enable bit and always passes.
- R9: `irq` equals the OR of `masked_stat` one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| tx_thresh | input | LVL_W | Transmit low-water threshold |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_thresh | input | LVL_W | Receive high-water threshold |
| ev_tx_ovf | input | 1 | Transmit overflow event pulse |
| ev_rx_unf | input | 1 | Receive underflow event pulse |
| ev_rx_ovf | input | 1 | Receive overflow event pulse |
| ev_contend | input | 1 | Multi-master contention event pulse |
| clr_tx_ovf | input | 1 | Clear strobe for transmit overflow |
| clr_rx_unf | input | 1 | Clear strobe for receive underflow |
| clr_rx_ovf | input | 1 | Clear strobe for receive overflow |
| clr_contend | input | 1 | Clear strobe for contention |
| clr_all | input | 1 | Clear strobe for all sticky sources |
| mask_we | input | 1 | Enable register write strobe |
| mask_wdata | input | 5 | Enable register write data |
| raw_stat | output | 6 | Raw interrupt status |
| masked_stat | output | 6 | Enabled interrupt status |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench drives an event and the clear for the same bit in one cycle. A design that gives the clear priority would drop that bit and lose an interrupt. It fires each dedicated clear while every sticky bit is set, so a miswired strobe shows up as a neighbour bit vanishing. It raises `clr_all` while both level sources are active; a design that lets the clear reach those bits would show a zero in bit 0 or 4. Levels are swept across equality with their thresholds, which catches comparisons that are off by one in either direction. Enable writes land while sources are pending, which exposes masking that inverts the polarity, disables contention, or lets `irq` run ahead of the masked word.

// File: rtl/spi_irq_pkg.sv
// Package: shared source indices and widths for the SPI interrupt status unit.
// Assumes: the bit order below is decoded by software and must not change.
package spi_irq_pkg;
    localparam int NSRC     = 6;
    localparam int NMASK    = 5;
    localparam int NSTICKY  = 4;
    localparam int SRC_TXLO = 0;
    localparam int SRC_TXOV = 1;
    localparam int SRC_RXUN = 2;
    localparam int SRC_RXOV = 3;
    localparam int SRC_RXHI = 4;
    localparam int SRC_CONT = 5;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/spi_irq_level_src.sv
// Module: registers the two FIFO-occupancy sources from level/threshold compares.
// Assumes: levels and thresholds are unsigned and of equal width.
module spi_irq_level_src #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    output logic             tx_low_q,
    output logic             rx_high_q
);
    logic tx_low_d;
    logic rx_high_d;

    // Compare current occupancy with each threshold.
    always_comb begin
        tx_low_d  = (tx_level <= tx_thresh);
        rx_high_d = (rx_level >  rx_thresh);
    end

    // Capture the comparisons so the status word comes straight from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_low_q  <= 1'b0;
            rx_high_q <= 1'b0;
        end else begin
            tx_low_q  <= tx_low_d;
            rx_high_q <= rx_high_d;
        end
    end
endmodule

// File: rtl/spi_irq_sticky.sv
// Module: a bank of set-by-event, clear-by-strobe status flops.
// Assumes: event pulses are single-cycle; a set overrides any clear in the same cycle.
module spi_irq_sticky #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] ev,
    input  logic [NBITS-1:0] clr,
    input  logic             clr_all,
    output logic [NBITS-1:0] stat_q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        // Each bit sets on its event, otherwise drops on its own or the global clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (ev[i])
                stat_q[i] <= 1'b1;
            else if (clr[i] || clr_all)
                stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_irq_mask.sv
// Module: holds the enable register, forms the masked status and the registered line.
// Assumes: the top source bit has no enable bit and always passes.
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  src_vec_t         raw,
    input  logic             mask_we,
    input  logic [NMASK-1:0] mask_wdata,
    output src_vec_t         masked,
    output logic             irq
);
    localparam int NFIXED = NSRC - NMASK;

    logic [NMASK-1:0] en_q;

    // Load the enable register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (mask_we)
            en_q <= mask_wdata;
    end

    // Gate raw sources with their enables; unmaskable bits pass through.
    always_comb begin
        masked = raw & {{NFIXED{1'b1}}, en_q};
    end

    // Register the combined line so the pin is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |masked;
    end
endmodule

// File: rtl/spi_irq_unit.sv
// Module: top of the SPI interrupt status unit. Merges the level sources and
// the sticky event sources into one raw word, then masks it and drives the line.
// Assumes: clear strobes come from the bus decoder as one-cycle pulses.
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             ev_tx_ovf,
    input  logic             ev_rx_unf,
    input  logic             ev_rx_ovf,
    input  logic             ev_contend,
    input  logic             clr_tx_ovf,
    input  logic             clr_rx_unf,
    input  logic             clr_rx_ovf,
    input  logic             clr_contend,
    input  logic             clr_all,
    input  logic             mask_we,
    input  logic [4:0]       mask_wdata,
    output logic [5:0]       raw_stat,
    output logic [5:0]       masked_stat,
    output logic             irq
);
    logic               tx_low;
    logic               rx_high;
    logic [NSTICKY-1:0] ev_vec;
    logic [NSTICKY-1:0] clr_vec;
    logic [NSTICKY-1:0] sticky;
    src_vec_t           raw;
    src_vec_t           masked;

    // Order sticky inputs as they appear in the status word.
    always_comb begin
        ev_vec  = {ev_contend, ev_rx_ovf, ev_rx_unf, ev_tx_ovf};
        clr_vec = {clr_contend, clr_rx_ovf, clr_rx_unf, clr_tx_ovf};
    end

    spi_irq_level_src #(.LVL_W(LVL_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_level (tx_level),
        .tx_thresh(tx_thresh),
        .rx_level (rx_level),
        .rx_thresh(rx_thresh),
        .tx_low_q (tx_low),
        .rx_high_q(rx_high)
    );

    spi_irq_sticky #(.NBITS(NSTICKY)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .clr    (clr_vec),
        .clr_all(clr_all),
        .stat_q (sticky)
    );

    // Assemble the raw word in software-visible order.
    always_comb begin
        raw           = '0;
        raw[SRC_TXLO] = tx_low;
        raw[SRC_TXOV] = sticky[0];
        raw[SRC_RXUN] = sticky[1];
        raw[SRC_RXOV] = sticky[2];
        raw[SRC_RXHI] = rx_high;
        raw[SRC_CONT] = sticky[3];
    end

    spi_irq_mask u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (raw),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .masked    (masked),
        .irq       (irq)
    );

    // Drive the outputs.
    always_comb begin
        raw_stat    = raw;
        masked_stat = masked;
    end
endmodule

// File: rtl/spi_irq_unit_chk.sv
// Module: property checker for spi_irq_unit, attached through bind.
// Assumes: it sees only the ports of the top module.
module spi_irq_unit_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] tx_thresh,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] rx_thresh,
    input logic             ev_tx_ovf,
    input logic             clr_tx_ovf,
    input logic             clr_all,
    input logic             ev_contend,
    input logic [5:0]       raw_stat,
    input logic [5:0]       masked_stat,
    input logic             irq
);
    // R2: the low-water bit follows the previous compare.
    a_r2_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> raw_stat[0] == $past(tx_level <= tx_thresh));

    // R3: the high-water bit follows the previous compare.
    a_r3_rx_high: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> raw_stat[4] == $past(rx_level > rx_thresh));

    // R4 and R7: an event always leaves its bit set.
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_ovf |=> raw_stat[1]);

    // R4: a sticky bit does not rise without its event.
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_contend && !raw_stat[5]) |=> !raw_stat[5]);

    // R5 and R6: a clear without an event drops the bit.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_tx_ovf || clr_all) && !ev_tx_ovf) |=> !raw_stat[1]);

    // R8: masked status never shows a source that is not raw.
    a_r8_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat & ~raw_stat) == 6'b0);

    // R8: contention has no enable bit.
    a_r8_contend_pass: assert property (@(posedge clk) disable iff (!rst_n)
        masked_stat[5] == raw_stat[5]);

    // R9: the line lags the masked word by one cycle.
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|masked_stat));
endmodule

bind spi_irq_unit spi_irq_unit_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .tx_thresh  (tx_thresh),
    .rx_level   (rx_level),
    .rx_thresh  (rx_thresh),
    .ev_tx_ovf  (ev_tx_ovf),
    .clr_tx_ovf (clr_tx_ovf),
    .clr_all    (clr_all),
    .ev_contend (ev_contend),
    .raw_stat   (raw_stat),
    .masked_stat(masked_stat),
    .irq        (irq)
);

// File: tb/spi_irq_unit_bench.sv
// Bench: directed corner cases plus seeded random stimulus, checked against a model.
module spi_irq_unit_bench;
    localparam int LVL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level = '0, tx_thresh = '0, rx_level = '0, rx_thresh = '0;
    logic ev_tx_ovf = 0, ev_rx_unf = 0, ev_rx_ovf = 0, ev_contend = 0;
    logic clr_tx_ovf = 0, clr_rx_unf = 0, clr_rx_ovf = 0, clr_contend = 0, clr_all = 0;
    logic             mask_we = 0;
    logic [4:0]       mask_wdata = '0;
    logic [5:0]       raw_stat, masked_stat;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [5:0] raw_m    = '0;
    logic [4:0] mask_m   = '0;
    logic [5:0] masked_m = '0;
    logic       irq_m    = 1'b0;

    always #2 clk = ~clk;

    spi_irq_unit #(.LVL_W(LVL_W)) u_spi_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .tx_thresh(tx_thresh),
        .rx_level(rx_level), .rx_thresh(rx_thresh),
        .ev_tx_ovf(ev_tx_ovf), .ev_rx_unf(ev_rx_unf),
        .ev_rx_ovf(ev_rx_ovf), .ev_contend(ev_contend),
        .clr_tx_ovf(clr_tx_ovf), .clr_rx_unf(clr_rx_unf),
        .clr_rx_ovf(clr_rx_ovf), .clr_contend(clr_contend), .clr_all(clr_all),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq)
    );

    // One sticky bit of the model: the event has priority over any clear.
    function automatic logic sticky_next(logic q, logic ev, logic clr);
        return ev ? 1'b1 : ((clr || clr_all) ? 1'b0 : q);
    endfunction

    // Model of the raw word after the next edge.
    function automatic logic [5:0] raw_next(logic [5:0] r);
        logic [5:0] n;
        n[0] = (tx_level <= tx_thresh);
        n[1] = sticky_next(r[1], ev_tx_ovf, clr_tx_ovf);
        n[2] = sticky_next(r[2], ev_rx_unf, clr_rx_unf);
        n[3] = sticky_next(r[3], ev_rx_ovf, clr_rx_ovf);
        n[4] = (rx_level > rx_thresh);
        n[5] = sticky_next(r[5], ev_contend, clr_contend);
        return n;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic zero_pulses();
        {ev_tx_ovf, ev_rx_unf, ev_rx_ovf, ev_contend} = '0;
        {clr_tx_ovf, clr_rx_unf, clr_rx_ovf, clr_contend, clr_all} = '0;
        mask_we = 0;
    endtask

    // Advance one edge, update the model, compare every output, return to a falling edge.
    task automatic cyc(string sticky_req);
        @(posedge clk);
        #1;
        irq_m    = |masked_m;
        raw_m    = raw_next(raw_m);
        if (mask_we) mask_m = mask_wdata;
        masked_m = raw_m & {1'b1, mask_m};
        check("R2 low-water bit0", int'(raw_stat[0]), int'(raw_m[0]));
        check("R3 high-water bit4", int'(raw_stat[4]), int'(raw_m[4]));
        check(sticky_req, int'({raw_stat[5], raw_stat[3:1]}), int'({raw_m[5], raw_m[3:1]}));
        check("R8 masked", int'(masked_stat), int'(masked_m));
        check("R9 irq", int'(irq), int'(irq_m));
        @(negedge clk);
        zero_pulses();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state of all outputs.
        check("R1 reset raw", int'(raw_stat), 0);
        check("R1 reset masked", int'(masked_stat), 0);
        check("R1 reset irq", int'(irq), 0);
        tx_level = 4'd5; tx_thresh = 4'd4; rx_level = 4'd3; rx_thresh = 4'd3;
        rst_n = 1'b1;
        cyc("R4 idle");

        // R2 and R3: equality and one step on each side of the thresholds.
        tx_level = 4'd4; cyc("R4");
        tx_level = 4'd3; rx_level = 4'd4; cyc("R4");
        rx_level = 4'd2; tx_level = 4'd15; tx_thresh = 4'd14; cyc("R4");

        // R4 and R1: set each sticky source in turn; enables still off.
        ev_tx_ovf = 1;  cyc("R4 tx overflow bit1");
        ev_rx_unf = 1;  cyc("R4 rx underflow bit2");
        ev_rx_ovf = 1;  cyc("R4 rx overflow bit3");
        ev_contend = 1; cyc("R4 contention bit5 passes mask");
        cyc("R4 hold");

        // R5: each dedicated clear touches only its own bit.
        clr_rx_unf = 1;  cyc("R5 clear rx underflow only");
        clr_tx_ovf = 1;  cyc("R5 clear tx overflow only");
        clr_contend = 1; cyc("R5 clear contention only");
        clr_rx_ovf = 1;  cyc("R5 clear rx overflow only");

        // R7: event and its clear in the same cycle leave the bit set.
        ev_rx_ovf = 1; clr_rx_ovf = 1; cyc("R7 event beats dedicated clear");
        ev_tx_ovf = 1; clr_all = 1;    cyc("R7 event beats clear-all");

        // R6: clear-all with both level sources active.
        tx_level = 4'd0; rx_level = 4'd9; rx_thresh = 4'd1;
        ev_contend = 1; ev_rx_unf = 1; cyc("R4 set");
        clr_all = 1; cyc("R6 clear-all keeps bits 0 and 4");

        // R8: enable writes while sources are pending.
        ev_rx_unf = 1; mask_we = 1; mask_wdata = 5'b10001; cyc("R8 enable bits 0,4");
        mask_we = 1; mask_wdata = 5'b00100; cyc("R8 enable bit2 only");
        tx_level = 4'd8; tx_thresh = 4'd1; rx_level = 4'd0;
        mask_we = 1; mask_wdata = 5'b00000; clr_rx_unf = 1; cyc("R9 line drops");
        cyc("R9 line low");

        // Random phase.
        for (int i = 0; i < 400; i++) begin
            tx_level   = LVL_W'($urandom_range(0, 15));
            tx_thresh  = LVL_W'($urandom_range(0, 15));
            rx_level   = LVL_W'($urandom_range(0, 15));
            rx_thresh  = LVL_W'($urandom_range(0, 15));
            ev_tx_ovf  = ($urandom_range(0, 7) == 0);
            ev_rx_unf  = ($urandom_range(0, 7) == 0);
            ev_rx_ovf  = ($urandom_range(0, 7) == 0);
            ev_contend = ($urandom_range(0, 7) == 0);
            clr_tx_ovf = ($urandom_range(0, 5) == 0);
            clr_rx_unf = ($urandom_range(0, 5) == 0);
            clr_rx_ovf = ($urandom_range(0, 5) == 0);
            clr_contend = ($urandom_range(0, 5) == 0);
            clr_all    = ($urandom_range(0, 15) == 0);
            mask_we    = ($urandom_range(0, 9) == 0);
            mask_wdata = 5'($urandom_range(0, 31));
            cyc("R5 R6 R7 random sticky");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule